// File: doc/BRIEF.md
# Execute-Stage Bypass Select Generator

This block drives the select lines of the operand bypass multiplexers in the execute stage of a five-stage in-order pipeline. It looks at three instruction words: the one about to execute (held between decode and execute), the one just past execute (held between execute and memory), and the one past memory (held between memory and writeback). From these words it works out whether a source register read by the executing instruction is about to be written by an older instruction still in flight. If so, it steers that operand to the in-flight value instead of the stale register-file value.

There are four bypass points: the two ALU operands, the store-data path into data memory, and the input of the branch zero test. Each gets a two-bit select that chooses the register file, the ALU result waiting in the execute/memory register, or the result waiting in the memory/writeback register. That last result is either an ALU value or loaded data. The block is purely combinational. Stall insertion for a load followed by a dependent instruction belongs to a separate interlock unit.

Top module: `fwd_select`

## Requirements
- R1: Every select uses 00 for the register file, 01 for the execute/memory result and 10 for the memory/writeback result. The value 11 never appears.
- R2: Field layout, MSB first: opcode IR[31:26], first source IR[25:21], second field IR[20:16], third field IR[15:11]. ALU operand A compares the first source when the executing opcode is register-register (6'h00), register-immediate (6'h08 to 6'h0F), load (6'h23) or store (6'h2B).
- R3: ALU operand B compares the second field IR[20:16] only for a register-register consumer. For any other consumer class it selects the register file.
- R4: The store-data select compares IR[20:16] only when the executing opcode is a store (6'h2B). Otherwise it is 00.
- R5: The zero-test select compares IR[25:21] only when the executing opcode is a branch (6'h04 or 6'h05). Otherwise it is 00.
- R6: A register-register producer writes the register in IR[15:11]. A register-immediate or load producer writes the register in IR[20:16]. The other slice of a producer is never compared.
- R7: Stores, branches and all other opcodes never act as producers, whatever their register fields hold.
- R8: When both in-flight instructions write the register a consumer reads, the execute/memory one is selected.
- R9: Register 0 is never forwarded, even when a producer names it as its destination.
- R10: A load in the execute/memory register is never a bypass source, so the select falls back to a memory/writeback match or to the register file. A load in the memory/writeback register is a source.
- R11: The selects follow the instruction inputs with no clock cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir_ex | input | IR_W (32) | Instruction word entering execute (consumer) |
| ir_mem | input | IR_W (32) | Instruction word in the execute/memory register (newer producer) |
| ir_wb | input | IR_W (32) | Instruction word in the memory/writeback register (older producer) |
| sel_op_a | output | 2 | Bypass select for ALU operand A |
| sel_op_b | output | 2 | Bypass select for ALU operand B |
| sel_st_data | output | 2 | Bypass select for store write data |
| sel_zero | output | 2 | Bypass select for the branch zero-test input |

## Verification
The hardest cases to reach are those where the wrong destination slice of a producer holds the very register the consumer reads. An example is a register-immediate producer whose immediate bits happen to spell the source number. Another is a register-register producer whose second source matches. Only then does a decoder that uses the wrong slice give a visibly wrong select. The stimulus builds instruction words field by field so that these accidental matches are placed on purpose. It also places both producers on one register to show priority, and it puts a load in the newer slot over a matching load in the older slot.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   localparam int OPC_W = 6;

   localparam logic [OPC_W-1:0] OPC_REG     = 6'h00;
   localparam logic [OPC_W-1:0] OPC_BR_Z    = 6'h04;
   localparam logic [OPC_W-1:0] OPC_BR_NZ   = 6'h05;
   localparam logic [OPC_W-1:0] OPC_LOAD    = 6'h23;
   localparam logic [OPC_W-1:0] OPC_STORE   = 6'h2B;

   typedef enum logic [1:0] {
      SRC_RF  = 2'b00,
      SRC_EXM = 2'b01,
      SRC_MWB = 2'b10
   } fwd_src_e;

   typedef enum logic [2:0] {
      CL_REG, CL_IMM, CL_LOAD, CL_STORE, CL_BRANCH, CL_OTHER
   } iclass_e;

   function automatic iclass_e classify(input logic [OPC_W-1:0] op);
      if (op == OPC_REG)                       return CL_REG;
      else if (op[OPC_W-1:3] == 3'b001)        return CL_IMM;
      else if (op == OPC_LOAD)                 return CL_LOAD;
      else if (op == OPC_STORE)                return CL_STORE;
      else if (op == OPC_BR_Z || op == OPC_BR_NZ) return CL_BRANCH;
      else                                     return CL_OTHER;
   endfunction

endpackage

// File: rtl/fwd_decode.sv
module fwd_decode
   import fwd_pkg::*;
#(
   parameter int IR_W       = 32,
   parameter int REG_W      = 5,
   parameter bit LOAD_SRC   = 1'b1,
   parameter bit ZERO_FIXED = 1'b1
) (
   input  logic [IR_W-1:0]  ir,
   output logic             dst_ok,
   output logic [REG_W-1:0] dst
);
   localparam int F2_HI = IR_W - OPC_W - REG_W - 1;
   localparam int F3_HI = F2_HI - REG_W;
   localparam int LOW_HI = F3_HI - REG_W;

   if (IR_W <= OPC_W + 3*REG_W) begin : g_bad_width
      $error("fwd_decode: IR_W too small for the field layout");
   end

   iclass_e          cls;
   logic             writes;
   logic [REG_W-1:0] f2, f3;
   logic             unused_bits;

   assign cls = classify(ir[IR_W-1 -: OPC_W]);
   assign f2  = ir[F2_HI -: REG_W];
   assign f3  = ir[F3_HI -: REG_W];
   assign unused_bits = ^{ir[IR_W-OPC_W-1 -: REG_W], ir[LOW_HI:0]};

   always_comb begin
      writes = 1'b0;
      dst    = '0;
      unique case (cls)
         CL_REG:  begin writes = 1'b1;     dst = f3; end
         CL_IMM:  begin writes = 1'b1;     dst = f2; end
         CL_LOAD: begin writes = LOAD_SRC; dst = f2; end
         default: begin writes = 1'b0;     dst = '0; end
      endcase
   end

   if (ZERO_FIXED) begin : g_zero_fixed
      assign dst_ok = writes && (dst != '0);
   end else begin : g_zero_free
      assign dst_ok = writes;
   end

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
   import fwd_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic             need,
   input  logic [REG_W-1:0] src,
   input  logic             exm_ok,
   input  logic [REG_W-1:0] exm_dst,
   input  logic             mwb_ok,
   input  logic [REG_W-1:0] mwb_dst,
   output logic [1:0]       sel
);
   always_comb begin
      sel = SRC_RF;
      if (need) begin
         if (exm_ok && (exm_dst == src))      sel = SRC_EXM;
         else if (mwb_ok && (mwb_dst == src)) sel = SRC_MWB;
      end
   end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
   import fwd_pkg::*;
#(
   parameter int IR_W       = 32,
   parameter int REG_W      = 5,
   parameter bit ZERO_FIXED = 1'b1
) (
   input  logic [IR_W-1:0] ir_ex,
   input  logic [IR_W-1:0] ir_mem,
   input  logic [IR_W-1:0] ir_wb,
   output logic [1:0]      sel_op_a,
   output logic [1:0]      sel_op_b,
   output logic [1:0]      sel_st_data,
   output logic [1:0]      sel_zero
);
   localparam int N_DST = 4;
   localparam int F1_HI = IR_W - OPC_W - 1;
   localparam int F2_HI = F1_HI - REG_W;
   localparam int REST_HI = F2_HI - REG_W;

   if (REG_W < 1 || IR_W <= OPC_W + 3*REG_W) begin : g_bad_param
      $error("fwd_select: illegal IR_W/REG_W combination");
   end

   iclass_e          ex_cls, mem_cls;
   logic [REG_W-1:0] rs1, rs2;
   logic             unused_ex_bits;
   logic             exm_ok, mwb_ok;
   logic [REG_W-1:0] exm_dst, mwb_dst;
   logic             need [N_DST];
   logic [REG_W-1:0] src  [N_DST];
   logic [1:0]       sel  [N_DST];

   assign ex_cls  = classify(ir_ex[IR_W-1 -: OPC_W]);
   assign mem_cls = classify(ir_mem[IR_W-1 -: OPC_W]);
   assign rs1 = ir_ex[F1_HI -: REG_W];
   assign rs2 = ir_ex[F2_HI -: REG_W];
   assign unused_ex_bits = ^ir_ex[REST_HI:0];

   fwd_decode #(.IR_W(IR_W), .REG_W(REG_W), .LOAD_SRC(1'b0), .ZERO_FIXED(ZERO_FIXED))
      u_dec_mem (.ir(ir_mem), .dst_ok(exm_ok), .dst(exm_dst));

   fwd_decode #(.IR_W(IR_W), .REG_W(REG_W), .LOAD_SRC(1'b1), .ZERO_FIXED(ZERO_FIXED))
      u_dec_wb  (.ir(ir_wb), .dst_ok(mwb_ok), .dst(mwb_dst));

   // consumer enables: 0 = op A, 1 = op B, 2 = store data, 3 = zero test
   assign need[0] = (ex_cls == CL_REG) || (ex_cls == CL_IMM) ||
                    (ex_cls == CL_LOAD) || (ex_cls == CL_STORE);
   assign need[1] = (ex_cls == CL_REG);
   assign need[2] = (ex_cls == CL_STORE);
   assign need[3] = (ex_cls == CL_BRANCH);
   assign src[0]  = rs1;
   assign src[1]  = rs2;
   assign src[2]  = rs2;
   assign src[3]  = rs1;

   for (genvar i = 0; i < N_DST; i++) begin : g_dst
      fwd_pick #(.REG_W(REG_W)) u_pick (
         .need    (need[i]),
         .src     (src[i]),
         .exm_ok  (exm_ok),
         .exm_dst (exm_dst),
         .mwb_ok  (mwb_ok),
         .mwb_dst (mwb_dst),
         .sel     (sel[i])
      );

      always_comb begin
         assert_sel_code_R1: assert (sel[i] != 2'b11)
            else $error("select %0d produced reserved code", i);
         assert_newest_wins_R8: assert (!(need[i] && exm_ok && exm_dst == src[i]) ||
                                        sel[i] == SRC_EXM)
            else $error("select %0d ignored a newer producer", i);
         assert_no_load_exm_R10: assert (mem_cls != CL_LOAD || sel[i] != SRC_EXM)
            else $error("select %0d bypassed from a load in EX/MEM", i);
         if (ZERO_FIXED) begin
            assert_no_zero_R9: assert (src[i] != '0 || sel[i] == SRC_RF)
               else $error("select %0d forwarded register 0", i);
         end
      end
   end

   assign sel_op_a    = sel[0];
   assign sel_op_b    = sel[1];
   assign sel_st_data = sel[2];
   assign sel_zero    = sel[3];

   always_comb begin
      assert_b_idle_R3: assert (ex_cls == CL_REG || sel_op_b == SRC_RF)
         else $error("operand B select active for non register-register consumer");
      assert_zero_idle_R5: assert (ex_cls == CL_BRANCH || sel_zero == SRC_RF)
         else $error("zero-test select active for non-branch consumer");
   end

endmodule

// File: tb/sim_fwd_select.sv
`timescale 1ns/1ps
module sim_fwd_select;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] ir_ex = '0, ir_mem = '0, ir_wb = '0;
   logic [1:0]  sel_op_a, sel_op_b, sel_st_data, sel_zero;

   always #4 clk = ~clk;

   fwd_select u0 (
      .ir_ex(ir_ex), .ir_mem(ir_mem), .ir_wb(ir_wb),
      .sel_op_a(sel_op_a), .sel_op_b(sel_op_b),
      .sel_st_data(sel_st_data), .sel_zero(sel_zero)
   );

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;

   function automatic logic [31:0] rr(input int rd, input int a, input int b);
      return {6'h00, a[4:0], b[4:0], rd[4:0], 11'h020};
   endfunction
   function automatic logic [31:0] it(input logic [5:0] op, input int a, input int b,
                                      input logic [15:0] imm);
      return {op, a[4:0], b[4:0], imm};
   endfunction

   task automatic drive(input logic [31:0] e, input logic [31:0] m, input logic [31:0] w,
                        input logic [1:0] a, input logic [1:0] b,
                        input logic [1:0] s, input logic [1:0] z, input string tag);
      item_t x;
      @(posedge clk);
      #1;
      ir_ex = e; ir_mem = m; ir_wb = w;
      x.exp = {a, b, s, z};
      x.tag = tag;
      q.push_back(x);
   endtask

   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t x;
         logic [7:0] got;
         x   = q.pop_front();
         got = {sel_op_a, sel_op_b, sel_st_data, sel_zero};
         checks++;
         if (got !== x.exp) begin
            fails++;
            $display("FAIL %s: got a/b/st/z=%b/%b/%b/%b expected %b/%b/%b/%b", x.tag,
                     got[7:6], got[5:4], got[3:2], got[1:0],
                     x.exp[7:6], x.exp[5:4], x.exp[3:2], x.exp[1:0]);
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: all-zero words -> register file everywhere (R1)
      drive('0, '0, '0, 2'b00, 2'b00, 2'b00, 2'b00, "R1 reset");
      // R2 R11: newer reg-reg producer into operand A
      drive(rr(3, 1, 2), rr(1, 7, 8), '0, 2'b01, 2'b00, 2'b00, 2'b00, "R2 R11 opA from EX/MEM");
      // R3: operand B from EX/MEM
      drive(rr(3, 1, 2), rr(2, 7, 8), '0, 2'b00, 2'b01, 2'b00, 2'b00, "R3 opB from EX/MEM");
      // R6: reg-imm producer in MEM/WB writes IR[20:16]=2; imm bits 15:11 spell 5
      drive(rr(3, 5, 2), '0, it(6'h08, 7, 2, {5'd5, 11'd0}),
            2'b00, 2'b10, 2'b00, 2'b00, "R6 imm dest slice");
      // R6: reg-reg producer whose IR[20:16]=3 must not match
      drive(rr(3, 3, 6), rr(9, 4, 3), '0, 2'b00, 2'b00, 2'b00, 2'b00, "R6 reg-reg dest slice");
      // R8: both producers write r4
      drive(rr(1, 4, 4), rr(4, 7, 8), rr(4, 9, 10), 2'b01, 2'b01, 2'b00, 2'b00, "R8 newest wins");
      // R8 R1: split sources
      drive(rr(1, 6, 4), rr(4, 7, 8), rr(6, 9, 10), 2'b10, 2'b01, 2'b00, 2'b00, "R8 R1 split");
      // R9: register 0 named as destination
      drive(rr(1, 0, 0), rr(0, 7, 8), it(6'h09, 7, 0, 16'h0000),
            2'b00, 2'b00, 2'b00, 2'b00, "R9 r0 never");
      // R10: load in EX/MEM is not a source
      drive(rr(1, 8, 2), it(6'h23, 3, 8, 16'h0004), '0, 2'b00, 2'b00, 2'b00, 2'b00, "R10 load EX/MEM");
      // R10: falls back to a matching load in MEM/WB
      drive(rr(1, 8, 2), it(6'h23, 3, 8, 16'h0004), it(6'h23, 3, 8, 16'h0008),
            2'b10, 2'b00, 2'b00, 2'b00, "R10 load MEM/WB");
      // R4: store base from MEM/WB, store data from EX/MEM
      drive(it(6'h2B, 3, 7, 16'h0010), rr(7, 1, 2), it(6'h08, 1, 3, 16'h0001),
            2'b10, 2'b00, 2'b01, 2'b00, "R4 store data");
      // R5: branch zero test from EX/MEM reg-imm
      drive(it(6'h04, 5, 5, 16'h0020), it(6'h0C, 1, 5, 16'h00FF), '0,
            2'b00, 2'b00, 2'b00, 2'b01, "R5 branch zero");
      // R5: bnez with MEM/WB load
      drive(it(6'h05, 6, 0, 16'h0020), '0, it(6'h23, 2, 6, 16'h0000),
            2'b00, 2'b00, 2'b00, 2'b10, "R5 bnez from load");
      // R7: store and branch in flight with matching fields never produce
      drive(rr(1, 5, 5), it(6'h2B, 5, 5, {5'd5, 11'd0}), it(6'h04, 5, 5, {5'd5, 11'd0}),
            2'b00, 2'b00, 2'b00, 2'b00, "R7 non-producers");
      // R2 R3: reg-imm consumer uses op A only
      drive(it(6'h0A, 9, 9, 16'h0003), rr(9, 1, 2), '0, 2'b01, 2'b00, 2'b00, 2'b00, "R2 R3 imm consumer");
      // R2: load consumer address from MEM/WB
      drive(it(6'h23, 6, 1, 16'h0000), '0, rr(6, 2, 3), 2'b10, 2'b00, 2'b00, 2'b00, "R2 load consumer");
      // R4 R5: non-store/non-branch consumer keeps those selects idle
      drive(rr(6, 6, 6), rr(6, 1, 2), '0, 2'b01, 2'b01, 2'b00, 2'b00, "R4 R5 idle paths");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule